// File: doc/BRIEF.md
# Programmable Sample Clock Generator

This block produces the sample clock for a flash converter front end. It runs on a single fabric clock. It takes its base rate either from that fabric clock, which plays the part of the on-board oscillator, or from an external clock pin. The external pin is resynchronised and its rising edges are turned into base steps. A 5-bit rate code selects a programmable divisor. The divided stream then always passes through a toggle stage, which halves the rate. Because of this the sample clock is high and low for the same number of base steps.

Besides the sample clock, the block emits a tick that lasts one fabric cycle. The tick marks each rising edge of the sample clock, so downstream capture logic can act on it without an edge detector of its own. The rate code is sampled only when a new sample period begins. Rewriting the code therefore never produces a runt or stretched half period.

Top module: `scg_sample_clk`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, `sample_clk` and `sample_tick` are low on the following cycle. After reset is released, the first rising edge of `sample_clk` occurs after exactly D base steps, where D is the divisor of the current rate code.
- R2: Rate code 0 bypasses the programmable stage (D = 1), so `sample_clk` toggles on every base step. The period is two base steps.
- R3: Rate codes 2 to 16 give D equal to the code value. `sample_clk` stays high for D base steps and low for D base steps.
- R4: Rate code 1 and codes 17 to 31 behave exactly as code 16.
- R5: `sample_tick` is high for exactly the fabric cycles in which `sample_clk` has just gone from low to high, and never on two consecutive cycles.
- R6: A change of `rate_code` takes effect only at the next rising edge of `sample_clk`. The period in progress completes both of its halves with the old divisor.
- R7: With `src_ext` high, one base step is taken per rising edge of `ext_clk`, after a two-flop synchroniser. For an external clock of period E fabric cycles, each half of `sample_clk` lasts D·E fabric cycles.
- R8: With `src_ext` low, every fabric clock cycle is a base step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; also the on-board base clock |
| rst | input | 1 | Synchronous reset, active high |
| src_ext | input | 1 | 1 selects the external clock pin as base source |
| ext_clk | input | 1 | External base clock, asynchronous to `clk` |
| rate_code | input | 5 | Rate field: 0 bypass, 2..16 divisor, others act as 16 |
| sample_clk | output | 1 | Sample clock, 50% duty |
| sample_tick | output | 1 | One-cycle pulse on each rising edge of `sample_clk` |

## Verification
The hardest case to reach is a rate rewrite that lands inside a sample period. Only at such a point does the choice of when the divisor is latched become visible. The stimulus waits for the first fabric cycle of a high half and rewrites the code there. Later it rewrites the code again on the first cycle of a low half. Half-period lengths are then measured across the boundary, so an early latch shows up as a wrong high or low length. The external source is exercised with a slow generated clock, and every code from 0 to 31 is swept on the on-board source.

// File: rtl/scg_pkg.sv
`timescale 1ns/1ps
package scg_pkg;
   localparam int unsigned SCG_RATE_W      = 5;
   localparam int unsigned SCG_DIV_MIN     = 2;
   localparam int unsigned SCG_DIV_MAX     = 16;
   localparam int unsigned SCG_BYPASS_CODE = 0;
   localparam int unsigned SCG_SYNC_STAGES = 2;

   typedef enum logic {
      SRC_ONBOARD  = 1'b0,
      SRC_EXTERNAL = 1'b1
   } scg_src_e;
endpackage

// File: rtl/scg_base_src.sv
`timescale 1ns/1ps
module scg_base_src
   import scg_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = SCG_SYNC_STAGES
) (
   input  logic     clk,
   input  logic     rst,
   input  scg_src_e src_sel,
   input  logic     ext_clk,
   output logic     base_step
);
   localparam int unsigned MSB = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_prev_q;
   logic                   ext_rise;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q     <= '0;
         ext_prev_q <= 1'b0;
      end else begin
         sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_clk};
         ext_prev_q <= sync_q[MSB];
      end
   end

   assign ext_rise  = sync_q[MSB] & ~ext_prev_q;
   assign base_step = (src_sel == SRC_EXTERNAL) ? ext_rise : 1'b1;

   // R7
   ext_step_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      (src_sel == SRC_EXTERNAL && base_step) |=> (src_sel != SRC_EXTERNAL || !base_step));

   // R8
   onboard_step_chk: assert property (@(posedge clk) disable iff (rst)
      (src_sel == SRC_ONBOARD) |-> base_step);
endmodule

// File: rtl/scg_rate_div.sv
`timescale 1ns/1ps
module scg_rate_div
   import scg_pkg::*;
#(
   parameter int unsigned RATE_W      = SCG_RATE_W,
   parameter int unsigned DIV_MIN     = SCG_DIV_MIN,
   parameter int unsigned DIV_MAX     = SCG_DIV_MAX,
   parameter int unsigned BYPASS_CODE = SCG_BYPASS_CODE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [RATE_W-1:0] rate_code,
   input  logic              step,
   input  logic              reload_ok,
   output logic              half_done
);
   localparam int unsigned DIV_W = $clog2(DIV_MAX + 1);

   function automatic logic [DIV_W-1:0] decode(input logic [RATE_W-1:0] code);
      int unsigned cv;
      cv = 32'(code);
      if (cv == BYPASS_CODE)
         return DIV_W'(1);
      else if (cv >= DIV_MIN && cv <= DIV_MAX)
         return DIV_W'(cv);
      else
         return DIV_W'(DIV_MAX);
   endfunction

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;
   logic             last;

   assign last      = step && (cnt_q == div_q - DIV_W'(1));
   assign half_done = last;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         div_q <= decode(rate_code);
      end else begin
         if (step)
            cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
         if (last && reload_ok)
            div_q <= decode(rate_code);
      end
   end

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q < div_q);

   // R6
   div_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$stable(div_q)) |-> $past(last && reload_ok));

   // R4
   div_legal_chk: assert property (@(posedge clk) disable iff (rst)
      (div_q == DIV_W'(1)) || (div_q >= DIV_W'(DIV_MIN) && div_q <= DIV_W'(DIV_MAX)));
endmodule

// File: rtl/scg_half_div.sv
`timescale 1ns/1ps
module scg_half_div (
   input  logic clk,
   input  logic rst,
   input  logic half_done,
   output logic sclk,
   output logic tick
);
   logic sclk_q;
   logic tick_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_q <= 1'b0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= half_done && !sclk_q;
         if (half_done)
            sclk_q <= !sclk_q;
      end
   end

   assign sclk = sclk_q;
   assign tick = tick_q;

   // R5
   tick_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
      tick_q |-> (sclk_q && !$past(sclk_q)));

   // R5
   tick_single_chk: assert property (@(posedge clk) disable iff (rst)
      tick_q |=> !tick_q);

   // R3
   toggle_cause_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && sclk_q != $past(sclk_q)) |-> $past(half_done));
endmodule

// File: rtl/scg_sample_clk.sv
`timescale 1ns/1ps
module scg_sample_clk
   import scg_pkg::*;
#(
   parameter int unsigned RATE_W      = SCG_RATE_W,
   parameter int unsigned DIV_MIN     = SCG_DIV_MIN,
   parameter int unsigned DIV_MAX     = SCG_DIV_MAX,
   parameter int unsigned BYPASS_CODE = SCG_BYPASS_CODE,
   parameter int unsigned SYNC_STAGES = SCG_SYNC_STAGES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              src_ext,
   input  logic              ext_clk,
   input  logic [RATE_W-1:0] rate_code,
   output logic              sample_clk,
   output logic              sample_tick
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DIV_MIN < 2 || DIV_MIN > DIV_MAX) begin : g_bad_div
         $error("divisor range must satisfy 2 <= DIV_MIN <= DIV_MAX");
      end
      if (DIV_MAX >= (1 << RATE_W)) begin : g_bad_width
         $error("DIV_MAX must be encodable in RATE_W bits");
      end
      if (BYPASS_CODE >= DIV_MIN && BYPASS_CODE <= DIV_MAX) begin : g_bad_bypass
         $error("bypass code collides with a divisor code");
      end
   endgenerate

   scg_src_e src_sel;
   logic     base_step;
   logic     half_done;
   logic     sclk;
   logic     tick;

   assign src_sel = src_ext ? SRC_EXTERNAL : SRC_ONBOARD;

   scg_base_src #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_src (
      .clk       (clk),
      .rst       (rst),
      .src_sel   (src_sel),
      .ext_clk   (ext_clk),
      .base_step (base_step)
   );

   scg_rate_div #(
      .RATE_W      (RATE_W),
      .DIV_MIN     (DIV_MIN),
      .DIV_MAX     (DIV_MAX),
      .BYPASS_CODE (BYPASS_CODE)
   ) u_div (
      .clk       (clk),
      .rst       (rst),
      .rate_code (rate_code),
      .step      (base_step),
      .reload_ok (!sclk),
      .half_done (half_done)
   );

   scg_half_div u_half (
      .clk       (clk),
      .rst       (rst),
      .half_done (half_done),
      .sclk      (sclk),
      .tick      (tick)
   );

   assign sample_clk  = sclk;
   assign sample_tick = tick;

   // R1
   reset_low_chk: assert property (@(posedge clk)
      $past(rst) |-> (!sample_clk && !sample_tick));
endmodule

// File: tb/scg_sample_clk_test.sv
`timescale 1ns/1ps
module scg_sample_clk_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       src_ext = 1'b0;
   logic       ext_clk = 1'b0;
   logic [4:0] rate_code = 5'd0;
   logic       sample_clk;
   logic       sample_tick;

   int tests = 0;
   int fails = 0;
   int tick_bad = 0;
   logic prev_sclk = 1'b0;
   logic ext_run = 1'b0;
   int ext_cnt = 0;
   localparam int EXT_HALF = 3;

   always #2.5 clk = ~clk;

   scg_sample_clk uut (
      .clk         (clk),
      .rst         (rst),
      .src_ext     (src_ext),
      .ext_clk     (ext_clk),
      .rate_code   (rate_code),
      .sample_clk  (sample_clk),
      .sample_tick (sample_tick)
   );

   // external clock: EXT_HALF fabric cycles high, EXT_HALF low
   always @(negedge clk) begin
      if (ext_run) begin
         ext_cnt = ext_cnt + 1;
         if (ext_cnt == EXT_HALF) begin
            ext_cnt = 0;
            ext_clk = ~ext_clk;
         end
      end
   end

   // R5 tick monitor
   always @(negedge clk) begin
      if (!rst && sample_tick !== (sample_clk && !prev_sclk))
         tick_bad = tick_bad + 1;
      prev_sclk = sample_clk;
   end

   function automatic int exp_div(input int code);
      if (code == 0) return 1;
      if (code >= 2 && code <= 16) return code;
      return 16;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      tests = tests + 1;
      if (act != exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input int code, input logic ext);
      @(negedge clk);
      rst = 1'b1;
      rate_code = 5'(code);
      src_ext = ext;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic first_rise(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n = n + 1;
      end while (!sample_clk);
   endtask

   task automatic run_len(output int n);
      logic lvl;
      lvl = sample_clk;
      n = 0;
      while (sample_clk == lvl) begin
         n = n + 1;
         @(negedge clk);
      end
   endtask

   initial begin
      int n;
      int d;
      int hi;
      int lo;
      // R1: reset state
      do_reset(5, 1'b0);
      rst = 1'b1;
      @(negedge clk);
      check("R1 sclk in reset", int'(sample_clk), 0);
      check("R1 tick in reset", int'(sample_tick), 0);

      // R2 R3 R4 R8: sweep every code on the on-board source
      for (int code = 0; code < 32; code++) begin
         d = exp_div(code);
         do_reset(code, 1'b0);
         first_rise(n);
         check(code == 0 ? "R2 first rise" : "R1 first rise", n, d);
         run_len(hi);
         run_len(lo);
         check(code == 0 ? "R2 high" : (d == code ? "R3 high" : "R4 high"), hi, d);
         check(code == 0 ? "R2 low" : (d == code ? "R3 low" : "R4 low"), lo, d);
         run_len(hi);
         check("R8 second high", hi, d);
      end

      // R1: reset during a high half forces the clock low
      do_reset(6, 1'b0);
      first_rise(n);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R1 reset mid-high", int'(sample_clk), 0);

      // R6: rewrite inside the high half, then inside the low half
      do_reset(4, 1'b0);
      first_rise(n);
      rate_code = 5'd10;
      run_len(hi);
      check("R6 old high", hi, 4);
      run_len(lo);
      check("R6 old low", lo, 4);
      run_len(hi);
      check("R6 new high", hi, 10);
      rate_code = 5'd3;
      run_len(lo);
      check("R6 held low", lo, 10);
      run_len(hi);
      check("R6 next high", hi, 3);
      run_len(lo);
      check("R6 next low", lo, 3);

      // R7: external source
      ext_run = 1'b1;
      for (int k = 0; k < 3; k++) begin
         int code;
         code = (k == 0) ? 0 : ((k == 1) ? 2 : 5);
         d = exp_div(code);
         do_reset(code, 1'b1);
         first_rise(n);
         run_len(hi);
         run_len(lo);
         run_len(hi);
         run_len(lo);
         check("R7 ext high", hi, d * 2 * EXT_HALF);
         check("R7 ext low", lo, d * 2 * EXT_HALF);
      end
      ext_run = 1'b0;

      // R5: tick matched every rising edge throughout
      check("R5 tick alignment errors", tick_bad, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule